// File: doc/BRIEF.md
# Flash Embedded-Operation Status Responder

This block stands on the device side of a NOR flash bank. It decides what a bus read returns while an internal program or erase is running. When a read hits the region that is busy, the block raises a flag that tells the data path to drive status bits in place of array contents. The status byte carries a data-polling bit, an operation toggle bit and a suspended-sector toggle bit. Reads outside the busy region keep returning array data with no extra delay. The block also drives an active-high ready line, which is low while an operation runs and while the bank recovers from a device reset.

Program and erase operations are started by single-cycle events. Their length is a parameterised cycle count, which lets a bench shorten the very long real durations. An erase can be suspended. While it is suspended, a program may run elsewhere in the same bank, and the erase can later be resumed for the cycles it has left. The device reset input aborts any activity. It holds the ready line low for a recovery window, and that window is longer when an operation was in flight or suspended.

Addresses are sector-granular. The upper `BANK_W` bits select the bank and the lower `SEC_W` bits select the sector inside that bank.

Top module: `fsr_status_resp`

## Requirements
- R1: An `op_start` accepted in the idle state drives `rdy` low from the next cycle. `rdy` stays low for exactly `PROG_CYC` cycles when `op_erase`=0 (program) or `ERASE_CYC` cycles when `op_erase`=1 (erase), and then returns high.
- R2: A read is active when `cs_n`=0 and `oe_n`=0. During a program, a read to the program's bank gives `status_sel`=1 and `stat_bits[7]` = NOT `op_d7`. During an erase, a read to the erase's bank gives `status_sel`=1 and `stat_bits[7]`=0. Bits 5:3 and 1:0 are always 0.
- R3: `stat_bits[6]` inverts after each completed status read during a program, an erase, or a program inside an erase suspend. The read counts as completed when `oe_n` or `cs_n` rises. The bit stays stable while a read is in progress and holds when no read occurs.
- R4: A read to any bank other than the busy one gives `status_sel`=0 and `stat_bits`=0.
- R5: In the idle state, reads give `status_sel`=0. This includes reads to the bank whose operation just finished, which now shows its true array data.
- R6: `op_suspend` during an erase freezes the erase and drives `rdy` high. A read to the suspended sector (same bank and same sector) gives `status_sel`=1 and `stat_bits[7]`=1, and bit 6 holds. Reads to any other sector give array data.
- R7: `stat_bits[2]` inverts after each completed read to the suspended sector while the erase is suspended. It holds at all other times, including during an active erase.
- R8: A program start while the erase is suspended is accepted. `rdy` stays low for `PROG_CYC` cycles, reads to the program's bank show program status, and the block then returns to the suspended state with `rdy` high.
- R9: `op_resume` while suspended restarts the erase for its remaining cycles. The cycle in which the suspend was taken does not count toward the erase length.
- R10: The block ignores the following: a start while a program or erase is running, a suspend outside an active erase, a resume outside the suspended state, and an erase start while suspended.
- R11: `dev_reset` aborts everything and clears both toggle bits to 0. After it, `rdy` stays low for `REC_BUSY` cycles if an operation was running or suspended, otherwise for `REC_IDLE` cycles. The block then becomes idle, and `status_sel` stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| dev_reset | input | 1 | Device reset request, active high |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | BANK_W+SEC_W | Read address {bank, sector} |
| op_start | input | 1 | Single-cycle operation start |
| op_erase | input | 1 | Start kind: 1 erase, 0 program |
| op_addr | input | BANK_W+SEC_W | Target {bank, sector} of the started operation |
| op_d7 | input | 1 | Bit 7 of the word being programmed |
| op_suspend | input | 1 | Single-cycle erase suspend request |
| op_resume | input | 1 | Single-cycle erase resume request |
| rdy | output | 1 | Ready (1) or busy (0) |
| status_sel | output | 1 | 1 when status replaces array data on the current read |
| stat_bits | output | 8 | Status byte: bit 7 polling, bit 6 toggle, bit 2 suspended-sector toggle |

## Verification
The bench targets the toggle bits across reads strobed by `oe_n` and by `cs_n`. A design that advanced them on the wrong edge, or while idle, would show a wrong value on the next read. It also targets the suspended sector against its neighbours in the same bank: a design that compared only the bank would return status where array data belongs. Ignored starts, suspends and resumes are checked through the exact busy length. A design that restarted its counter would stay busy too long. Reset recovery is measured both after an aborted operation and from idle, so a design with a single recovery window fails one of the two. Seeded random reads during an erase cover bank selection in bulk.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_SUSP  = 3'd3,
        ST_SPROG = 3'd4,
        ST_RECOV = 3'd5
    } fsr_state_e;

endpackage

// File: rtl/fsr_addr_match.sv
// Compares two {bank, sector} addresses; CMP_SEC selects bank-only or full compare.
module fsr_addr_match #(
    parameter int BANK_W  = 2,
    parameter int SEC_W   = 3,
    parameter bit CMP_SEC = 1'b0
) (
    input  logic [BANK_W+SEC_W-1:0] a,
    input  logic [BANK_W+SEC_W-1:0] b,
    output logic                    hit
);
    localparam int REG_W = BANK_W + SEC_W;

    logic [REG_W-1:0] mask;

    generate
        if (CMP_SEC) begin : g_full
            assign mask = {REG_W{1'b1}};
        end else begin : g_bank
            assign mask = {{BANK_W{1'b1}}, {SEC_W{1'b0}}};
        end
    endgenerate

    assign hit = ((a ^ b) & mask) == '0;

endmodule

// File: rtl/fsr_toggle_bit.sv
// Status toggle bit: flips when a qualifying read ends, clears on request.
module fsr_toggle_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rd,
    input  logic qual,
    output logic bit_o
);
    typedef struct packed {
        logic armed;
        logic val;
    } tog_t;

    tog_t d, q;

    always_comb begin
        d       = q;
        d.armed = rd & qual;
        if (q.armed && !rd) begin
            d.val = ~q.val;
        end
        if (clr) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign bit_o = q.val;

endmodule

// File: rtl/fsr_status_resp.sv
module fsr_status_resp
    import fsr_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int SEC_W     = 3,
    parameter int PROG_CYC  = 700,
    parameter int ERASE_CYC = 40000000,
    parameter int REC_BUSY  = 2000,
    parameter int REC_IDLE  = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dev_reset,
    input  logic                    cs_n,
    input  logic                    oe_n,
    input  logic [BANK_W+SEC_W-1:0] addr,
    input  logic                    op_start,
    input  logic                    op_erase,
    input  logic [BANK_W+SEC_W-1:0] op_addr,
    input  logic                    op_d7,
    input  logic                    op_suspend,
    input  logic                    op_resume,
    output logic                    rdy,
    output logic                    status_sel,
    output logic [7:0]              stat_bits
);
    localparam int REG_W   = BANK_W + SEC_W;
    localparam int MAX_OP  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_REC = (REC_BUSY > REC_IDLE) ? REC_BUSY : REC_IDLE;
    localparam int MAX_CNT = (MAX_OP > MAX_REC) ? MAX_OP : MAX_REC;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int N_TOG   = 2;

    typedef struct packed {
        fsr_state_e       st;
        logic [REG_W-1:0] pa;
        logic [REG_W-1:0] ea;
        logic             d7;
        logic [CNT_W-1:0] pcnt;
        logic [CNT_W-1:0] ecnt;
        logic [CNT_W-1:0] rcnt;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, default: '0};
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ctl_t d, q;

    logic             rd;
    logic             hit_pb, hit_eb, hit_es;
    logic             sel_c, b7, busy_st;
    logic [N_TOG-1:0] tq, tb;
    fsr_state_e       st_w;

    assign rd   = !cs_n && !oe_n;
    assign st_w = q.st;

    fsr_addr_match #(.BANK_W(BANK_W), .SEC_W(SEC_W), .CMP_SEC(1'b0)) u_m_pb (
        .a(addr), .b(q.pa), .hit(hit_pb));
    fsr_addr_match #(.BANK_W(BANK_W), .SEC_W(SEC_W), .CMP_SEC(1'b0)) u_m_eb (
        .a(addr), .b(q.ea), .hit(hit_eb));
    fsr_addr_match #(.BANK_W(BANK_W), .SEC_W(SEC_W), .CMP_SEC(1'b1)) u_m_es (
        .a(addr), .b(q.ea), .hit(hit_es));

    // Next-state computation
    always_comb begin
        d = q;
        if (dev_reset && q.st != ST_RECOV) begin
            d.st   = ST_RECOV;
            d.rcnt = (q.st != ST_IDLE) ? CNT_W'(REC_BUSY) : CNT_W'(REC_IDLE);
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (op_start) begin
                        if (op_erase) begin
                            d.st   = ST_ERASE;
                            d.ea   = op_addr;
                            d.ecnt = CNT_W'(ERASE_CYC);
                        end else begin
                            d.st   = ST_PROG;
                            d.pa   = op_addr;
                            d.d7   = op_d7;
                            d.pcnt = CNT_W'(PROG_CYC);
                        end
                    end
                end
                ST_PROG: begin
                    if (q.pcnt == ONE) d.st = ST_IDLE;
                    else               d.pcnt = q.pcnt - ONE;
                end
                ST_ERASE: begin
                    if (op_suspend)         d.st = ST_SUSP;
                    else if (q.ecnt == ONE) d.st = ST_IDLE;
                    else                    d.ecnt = q.ecnt - ONE;
                end
                ST_SUSP: begin
                    if (op_resume) begin
                        d.st = ST_ERASE;
                    end else if (op_start && !op_erase) begin
                        d.st   = ST_SPROG;
                        d.pa   = op_addr;
                        d.d7   = op_d7;
                        d.pcnt = CNT_W'(PROG_CYC);
                    end
                end
                ST_SPROG: begin
                    if (q.pcnt == ONE) d.st = ST_SUSP;
                    else               d.pcnt = q.pcnt - ONE;
                end
                ST_RECOV: begin
                    if (q.rcnt != ONE) d.rcnt = q.rcnt - ONE;
                    else if (!dev_reset) d.st = ST_IDLE;
                end
                default: d = CTL_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    // Read-side decode
    always_comb begin
        sel_c   = 1'b0;
        b7      = 1'b0;
        busy_st = 1'b0;
        unique case (q.st)
            ST_PROG:  begin sel_c = hit_pb; b7 = ~q.d7; busy_st = 1'b1; end
            ST_ERASE: begin sel_c = hit_eb; b7 = 1'b0;  busy_st = 1'b1; end
            ST_SUSP:  begin sel_c = hit_es; b7 = 1'b1;                  end
            ST_SPROG: begin sel_c = hit_pb; b7 = ~q.d7; busy_st = 1'b1; end
            default:  begin end
        endcase
    end

    assign status_sel = rd && sel_c;
    assign tq[0]      = status_sel && busy_st;
    assign tq[1]      = status_sel && (q.st == ST_SUSP);

    generate
        for (genvar g = 0; g < N_TOG; g++) begin : g_tog
            fsr_toggle_bit u_tog (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (dev_reset),
                .rd    (rd),
                .qual  (tq[g]),
                .bit_o (tb[g])
            );
        end
    endgenerate

    assign rdy       = !(busy_st || q.st == ST_RECOV);
    assign stat_bits = status_sel ? {b7, tb[0], 3'b000, tb[1], 2'b00} : 8'h00;

endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk
    import fsr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       dev_reset,
    input logic       cs_n,
    input logic       oe_n,
    input logic       op_start,
    input logic       rdy,
    input logic       status_sel,
    input fsr_state_e st,
    input logic       t6,
    input logic       t2
);
    logic rd, rd_prev;

    assign rd = !cs_n && !oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd;
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && op_start && !dev_reset) |=> !rdy); // R1

    AST_RDY_RISE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> (st == ST_IDLE || st == ST_SUSP)); // R1

    AST_IDLE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_RECOV) |-> !status_sel); // R5

    AST_T6_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_reset && !(rd_prev && !rd)) |=> $stable(t6)); // R3

    AST_T2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dev_reset && !(rd_prev && !rd)) |=> $stable(t2)); // R7

    AST_RESET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset |=> (!rdy && !t6 && !t2)); // R11

endmodule

bind fsr_status_resp fsr_status_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dev_reset  (dev_reset),
    .cs_n       (cs_n),
    .oe_n       (oe_n),
    .op_start   (op_start),
    .rdy        (rdy),
    .status_sel (status_sel),
    .st         (st_w),
    .t6         (tb[0]),
    .t2         (tb[1])
);

// File: tb/tb_fsr_status_resp.sv
`timescale 1ns/1ps
module tb_fsr_status_resp;
    localparam int BW      = 2;
    localparam int SW      = 3;
    localparam int RW      = BW + SW;
    localparam int PROG_N  = 12;
    localparam int ERASE_N = 200;
    localparam int RB      = 10;
    localparam int RI      = 3;

    logic          clk = 1'b0;
    logic          rst_n, dev_reset, cs_n, oe_n;
    logic [RW-1:0] addr, op_addr;
    logic          op_start, op_erase, op_d7, op_suspend, op_resume;
    logic          rdy, status_sel;
    logic [7:0]    stat_bits;

    int checks = 0;
    int errors = 0;
    logic e6 = 1'b0;
    logic e2 = 1'b0;

    always #4 clk = ~clk;

    fsr_status_resp #(
        .BANK_W(BW), .SEC_W(SW), .PROG_CYC(PROG_N), .ERASE_CYC(ERASE_N),
        .REC_BUSY(RB), .REC_IDLE(RI)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dev_reset(dev_reset), .cs_n(cs_n), .oe_n(oe_n),
        .addr(addr), .op_start(op_start), .op_erase(op_erase), .op_addr(op_addr),
        .op_d7(op_d7), .op_suspend(op_suspend), .op_resume(op_resume),
        .rdy(rdy), .status_sel(status_sel), .stat_bits(stat_bits)
    );

    function automatic logic [RW-1:0] mk(input int b, input int s);
        return {BW'(b), SW'(s)};
    endfunction

    function automatic logic [7:0] exp_stat(input logic sel, input logic b7,
                                            input logic b6, input logic b2);
        return sel ? {b7, b6, 3'b000, b2, 2'b00} : 8'h00;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One read lasting one rising edge; returns two cycles later at a negedge.
    task automatic rd_chk(input logic [RW-1:0] a, input bit via_cs, input bit es,
                          input bit e7, input bit t6, input bit t2, input string rq);
        addr = a; cs_n = 1'b0; oe_n = 1'b0;
        #1;
        chk(rq, 32'(status_sel), 32'(es));
        chk(rq, 32'(stat_bits), 32'(exp_stat(es, e7, e6, e2)));
        @(negedge clk);
        if (via_cs) cs_n = 1'b1; else oe_n = 1'b1;
        @(negedge clk);
        if (t6) e6 = ~e6;
        if (t2) e2 = ~e2;
    endtask

    task automatic pulse_start(input bit er, input logic [RW-1:0] a, input bit dv);
        op_start = 1'b1; op_erase = er; op_addr = a; op_d7 = dv;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic pulse_susp();
        op_suspend = 1'b1; @(negedge clk); op_suspend = 1'b0;
    endtask

    task automatic pulse_resume();
        op_resume = 1'b1; @(negedge clk); op_resume = 1'b0;
    endtask

    task automatic pulse_reset();
        dev_reset = 1'b1; @(negedge clk); dev_reset = 1'b0;
        e6 = 1'b0; e2 = 1'b0;
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!rdy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        int n;
        logic [RW-1:0] a;
        bit vc, es;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; dev_reset = 1'b0; cs_n = 1'b1; oe_n = 1'b1; addr = '0;
        op_start = 1'b0; op_erase = 1'b0; op_addr = '0; op_d7 = 1'b0;
        op_suspend = 1'b0; op_resume = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        chk("R5 reset rdy", 32'(rdy), 1);
        rd_chk(mk(2, 3), 0, 0, 0, 0, 0, "R5 reset read");

        // R1 program duration
        pulse_start(0, mk(2, 3), 1);
        chk("R1 busy after start", 32'(rdy), 0);
        count_low(n);
        chk("R1 program length", 32'(n), 32'(PROG_N));

        // R2/R3/R4/R5 polling and toggle during program
        pulse_start(0, mk(2, 4), 0);
        rd_chk(mk(2, 7), 0, 1, 1, 1, 0, "R2 R3 program poll via OE");
        rd_chk(mk(2, 0), 1, 1, 1, 1, 0, "R2 R3 program poll via CS");
        rd_chk(mk(2, 5), 0, 1, 1, 1, 0, "R3 third toggle");
        rd_chk(mk(0, 4), 0, 0, 0, 0, 0, "R4 other bank during program");
        rd_chk(mk(3, 4), 1, 0, 0, 0, 0, "R4 other bank via CS");
        count_low(n);
        rd_chk(mk(2, 4), 0, 0, 0, 0, 0, "R5 array after program done");

        // R10 ignored events while busy and idle
        pulse_start(0, mk(2, 1), 1);
        pulse_start(1, mk(0, 0), 0);
        pulse_susp();
        count_low(n);
        chk("R10 start and suspend ignored while programming", 32'(n + 2), 32'(PROG_N));
        pulse_resume();
        chk("R10 resume ignored when idle", 32'(rdy), 1);
        rd_chk(mk(0, 0), 0, 0, 0, 0, 0, "R10 no erase started");

        // R1 erase duration
        pulse_start(1, mk(3, 1), 0);
        count_low(n);
        chk("R1 erase length", 32'(n), 32'(ERASE_N));

        // Random reads during an erase of bank 1
        pulse_start(1, mk(1, 2), 0);
        for (int i = 0; i < 24; i++) begin
            a  = RW'($urandom);
            vc = 1'($urandom);
            es = (a[RW-1 -: BW] == BW'(1));
            rd_chk(a, vc, es, 0, es, 0, "R2 R3 R4 R7 random erase read");
        end
        count_low(n);
        rd_chk(mk(1, 2), 0, 0, 0, 0, 0, "R5 array after erase done");

        // Suspend, program in suspend, resume
        pulse_start(1, mk(1, 2), 0);
        rd_chk(mk(1, 6), 0, 1, 0, 1, 0, "R3 erase toggle");
        pulse_susp();
        chk("R6 ready while suspended", 32'(rdy), 1);
        rd_chk(mk(1, 2), 0, 1, 1, 0, 1, "R6 R7 suspended sector via OE");
        rd_chk(mk(1, 2), 1, 1, 1, 0, 1, "R6 R7 suspended sector via CS");
        rd_chk(mk(1, 5), 0, 0, 0, 0, 0, "R6 other sector same bank");
        rd_chk(mk(3, 2), 0, 0, 0, 0, 0, "R6 other bank");
        pulse_start(1, mk(2, 0), 0);
        chk("R10 erase start ignored while suspended", 32'(rdy), 1);
        rd_chk(mk(1, 2), 0, 1, 1, 0, 1, "R10 suspend target unchanged");
        pulse_start(0, mk(1, 0), 0);
        rd_chk(mk(1, 0), 0, 1, 1, 1, 0, "R8 program status in suspend");
        count_low(n);
        chk("R8 program length in suspend", 32'(n + 2), 32'(PROG_N));
        chk("R8 back to suspended ready", 32'(rdy), 1);
        rd_chk(mk(1, 2), 1, 1, 1, 0, 1, "R8 R7 still suspended");
        pulse_resume();
        count_low(n);
        chk("R9 remaining erase length", 32'(n), 32'(ERASE_N - 2));
        rd_chk(mk(1, 2), 0, 0, 0, 0, 0, "R9 R5 array after resumed erase");

        // R11 reset recovery
        pulse_start(0, mk(0, 1), 1);
        rd_chk(mk(0, 1), 0, 1, 0, 1, 0, "R11 pre-reset read");
        if (!e6) rd_chk(mk(0, 1), 0, 1, 0, 1, 0, "R11 pre-reset read");
        pulse_reset();
        count_low(n);
        chk("R11 recovery after busy", 32'(n), 32'(RB));
        rd_chk(mk(0, 1), 0, 0, 0, 0, 0, "R11 array after reset");
        pulse_start(0, mk(0, 1), 1);
        rd_chk(mk(0, 1), 0, 1, 0, 1, 0, "R11 toggle cleared by reset");
        count_low(n);
        pulse_reset();
        count_low(n);
        chk("R11 recovery from idle", 32'(n), 32'(RI));
        chk("R11 ready after recovery", 32'(rdy), 1);

        summary();
    end
endmodule